// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two W-bit buses, called side A and side B, through two independent paths. The A-to-B path carries data from bus A onto bus B. The B-to-A path carries data from bus B onto bus A. Each path owns a capture register, and that register has its own capture clock. On every rising edge of that clock, the register samples the bus the path reads from.

A path can drive its output bus in one of two ways. In the live setting it passes the opposite bus straight through. In the stored setting it plays back the captured word. The output enable decides whether the path drives at all, and the two enables have opposite polarity.

Every bus line is split into an input vector, an output vector and an output-enable flag. This keeps the block free of internal tri-states. The surrounding logic, or a wired-bus model in the bench, resolves the shared lines.

Each path is described by a small combinational mode machine with three named modes:
- OFF: the output enable is inactive.
- LIVE: the enable is active and the select is low.
- STORED: the enable is active and the select is high.

The enable moves a path between OFF and either driving mode. The select moves a path between LIVE and STORED. The mode changes in the same instant as its controls, with no intermediate mode.

Combined settings of the two paths give the system-level functions:
- isolation;
- storage from either bus, or from both buses;
- copying one bus into both registers;
- simultaneous playback in both directions;
- a self-holding loop, in which each bus reinforces the other.

Top module: `bus_xcvr_reg`

## Requirements
- R1: An asynchronous active-low `rst_n` clears both capture registers to zero. It leaves the enables and selects in force, so a path in STORED mode drives zero during reset and its output-enable stays as the enable dictates.
- R2: `en_ab` is active high. When it is 1, `b_oe` is 1. When it is 0, `b_oe` is 0 and `b_out` is all zeros.
- R3: `en_ba_n` is active low. When it is 0, `a_oe` is 1. When it is 1, `a_oe` is 0 and `a_out` is all zeros.
- R4: While a path's enable is active, select value 0 drives the live opposite bus and select value 1 drives that path's register. For the A-to-B path, `sel_ab`=0 gives `b_out`=`a_in` combinationally, and `sel_ab`=1 gives the stored A word. For the B-to-A path, `sel_ba`=0 gives `a_out`=`b_in`, and `sel_ba`=1 gives the stored B word.
- R5: The A-to-B register loads `a_in` on every rising edge of `clk_ab`. The B-to-A register loads `b_in` on every rising edge of `clk_ba`. Both loads happen whatever the enables and selects are.
- R6: With `en_ab`=0 and `en_ba_n`=1, neither bus is driven, and both registers still capture their buses.
- R7: When the B-to-A path drives bus B live onto bus A, a `clk_ab` edge captures that driven value. Both registers can then hold the same bus B word.
- R8: With both selects 0 and both paths enabled, each bus drives the other. After the external source releases the buses, the last value is held on both.
- R9: When the live bus equals the stored word, toggling the select produces no change at all on the driven output.
- R10: With both selects 1 and both paths enabled, the stored A word appears on `b_out` and the stored B word appears on `a_out` at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_ba | input | 1 | Capture clock of the B-to-A register (rising edge) |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| en_ab | input | 1 | A-to-B output enable, active high |
| en_ba_n | input | 1 | B-to-A output enable, active low |
| sel_ab | input | 1 | A-to-B select: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A select: 0 live, 1 stored |
| a_in | input | W | Sampled value of bus A |
| a_out | output | W | Value driven onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Sampled value of bus B |
| b_out | output | W | Value driven onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench aims at the following corner cases, each paired with the failure it would expose:
- Enable polarity: a design that gives both enables the same polarity drives a bus during isolation, or releases it during playback.
- Capture gating: a register that loads only when its path is enabled or selected keeps a stale word, and the model disagrees at the next STORED playback.
- Cross-register copy: the copy through a live path fails if the register samples the wrong side.
- Self-holding loop: the loop drifts if either live path is broken.
- Select switching: a select multiplexer that passes through zero or a mixed word while it switches is caught by counting every change of `b_out` while the select toggles between equal sources.
- Reset: clearing the controls as well as the registers shows up as a dropped output-enable during reset.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Driving mode of one transfer path.
    typedef enum logic [1:0] {
        DRV_OFF    = 2'd0,
        DRV_LIVE   = 2'd1,
        DRV_STORED = 2'd2
    } drive_mode_e;

    // Path indices inside the top module.
    localparam int PATH_AB = 0;
    localparam int PATH_BA = 1;
    localparam int N_PATHS = 2;

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Loads on every rising edge; no enable by design.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
    import xcvr_pkg::*;
#(
    parameter int W             = 8,
    parameter bit EN_ACTIVE_LOW = 1'b0
) (
    input  logic         en,
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] dout,
    output logic         oe
);

    logic        en_act;
    drive_mode_e mode;
    logic [W-1:0] live_mask;
    logic [W-1:0] store_mask;

    // Enable polarity picked per path.
    generate
        if (EN_ACTIVE_LOW) begin : g_low
            assign en_act = ~en;
        end else begin : g_high
            assign en_act = en;
        end
    endgenerate

    // Mode decode: OFF, LIVE or STORED.
    always_comb begin
        if (!en_act) begin
            mode = DRV_OFF;
        end else if (sel) begin
            mode = DRV_STORED;
        end else begin
            mode = DRV_LIVE;
        end
    end

    // Mode outputs: masks and drive enable.
    always_comb begin
        live_mask  = '0;
        store_mask = '0;
        oe         = 1'b0;
        unique case (mode)
            DRV_OFF: begin
                oe = 1'b0;
            end
            DRV_LIVE: begin
                live_mask = {W{1'b1}};
                oe        = 1'b1;
            end
            DRV_STORED: begin
                store_mask = {W{1'b1}};
                oe         = 1'b1;
            end
            default: begin
                oe = 1'b0;
            end
        endcase
    end

    // AND-OR select: each bit is a sum of two gated terms, so equal sources
    // give an unchanged result across a select switch.
    assign dout = (live & live_mask) | (stored & store_mask);

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst_n,
    input  logic         en_ab,
    input  logic         en_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [N_PATHS-1:0] cap_clk;
    logic [N_PATHS-1:0] path_en;
    logic [N_PATHS-1:0] path_sel;
    logic [N_PATHS-1:0] path_oe;
    logic [W-1:0]       path_src  [N_PATHS];
    logic [W-1:0]       path_word [N_PATHS];
    logic [W-1:0]       path_dout [N_PATHS];

    assign cap_clk[PATH_AB]  = clk_ab;
    assign cap_clk[PATH_BA]  = clk_ba;
    assign path_en[PATH_AB]  = en_ab;
    assign path_en[PATH_BA]  = en_ba_n;
    assign path_sel[PATH_AB] = sel_ab;
    assign path_sel[PATH_BA] = sel_ba;
    assign path_src[PATH_AB] = a_in;
    assign path_src[PATH_BA] = b_in;

    // One capture register and one drive stage per path; the source bus
    // feeds both the register and the live leg.
    generate
        for (genvar g = 0; g < N_PATHS; g++) begin : g_path
            xcvr_capture #(
                .W(W)
            ) u_cap (
                .clk   (cap_clk[g]),
                .rst_n (rst_n),
                .d     (path_src[g]),
                .q     (path_word[g])
            );

            xcvr_drive #(
                .W             (W),
                .EN_ACTIVE_LOW (g == PATH_BA)
            ) u_drv (
                .en     (path_en[g]),
                .sel    (path_sel[g]),
                .live   (path_src[g]),
                .stored (path_word[g]),
                .dout   (path_dout[g]),
                .oe     (path_oe[g])
            );
        end
    endgenerate

    assign b_out = path_dout[PATH_AB];
    assign b_oe  = path_oe[PATH_AB];
    assign a_out = path_dout[PATH_BA];
    assign a_oe  = path_oe[PATH_BA];

endmodule

// File: rtl/bus_xcvr_reg_checker.sv
module bus_xcvr_reg_checker #(
    parameter int W = 8
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst_n,
    input logic         en_ab,
    input logic         en_ba_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe
);

    logic seen_ab;
    logic seen_ba;

    always_ff @(posedge clk_ab or negedge rst_n) begin
        if (!rst_n) seen_ab <= 1'b0;
        else        seen_ab <= 1'b1;
    end

    always_ff @(posedge clk_ba or negedge rst_n) begin
        if (!rst_n) seen_ba <= 1'b0;
        else        seen_ba <= 1'b1;
    end

    assert_b_release_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !en_ab |-> (!b_oe && b_out == '0));

    assert_b_drive_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
        en_ab |-> b_oe);

    assert_a_release_R3: assert property (@(posedge clk_ba) disable iff (!rst_n)
        en_ba_n |-> (!a_oe && a_out == '0));

    assert_a_drive_R3: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !en_ba_n |-> a_oe);

    assert_live_ab_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (en_ab && !sel_ab) |-> (b_out == a_in));

    assert_live_ba_R4: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (!en_ba_n && !sel_ba) |-> (a_out == b_in));

    assert_capture_ab_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (seen_ab && en_ab && sel_ab) |-> (b_out == $past(a_in)));

    assert_capture_ba_R5: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (seen_ba && !en_ba_n && sel_ba) |-> (a_out == $past(b_in)));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_checker #(.W(W)) u_chk (.*);

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic         clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
    logic         en_ab = 1'b1, en_ba_n = 1'b0, sel_ab = 1'b1, sel_ba = 1'b1;
    logic [W-1:0] bus_a = '0, bus_b = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic         ext_a_en = 1'b0, ext_b_en = 1'b0;
    logic [W-1:0] ext_a = '0, ext_b = '0;

    // Reference model state
    logic [W-1:0] m_ab = '0, m_ba = '0;
    string        tag = "R1";
    bit           cmp_on = 1'b0;
    bit           mon_on = 1'b0;
    int           b_changes = 0;
    int           checks = 0, errors = 0;
    logic [15:0]  lfsr = 16'hACE1;

    bus_xcvr_reg #(.W(W)) i_bus_xcvr_reg (
        .clk_ab (clk_ab), .clk_ba (clk_ba), .rst_n (rst_n),
        .en_ab (en_ab), .en_ba_n (en_ba_n), .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (bus_a), .a_out (a_out), .a_oe (a_oe),
        .b_in (bus_b), .b_out (b_out), .b_oe (b_oe)
    );

    // Wired-bus resolver: a driven output becomes the next bus value,
    // otherwise an external source, otherwise the bus keeps its state.
    always @(posedge clk) begin
        bus_a <= a_oe ? a_out : (ext_a_en ? ext_a : bus_a);
        bus_b <= b_oe ? b_out : (ext_b_en ? ext_b : bus_b);
    end

    always @(b_out) if (mon_on) b_changes++;

    task automatic check(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference compared every clock
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [W-1:0] eb, ea;
            eb = !en_ab ? '0 : (sel_ab ? m_ab : bus_a);
            ea = en_ba_n ? '0 : (sel_ba ? m_ba : bus_b);
            check("b_oe", {7'd0, b_oe}, {7'd0, en_ab});
            check("a_oe", {7'd0, a_oe}, {7'd0, ~en_ba_n});
            check("b_out", b_out, eb);
            check("a_out", a_out, ea);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic setc(input logic eab, input logic ebn, input logic sab, input logic sba);
        en_ab = eab; en_ba_n = ebn; sel_ab = sab; sel_ba = sba;
    endtask

    task automatic pulse_ab();
        #1 clk_ab = 1'b1; m_ab = bus_a;
        #1 clk_ab = 1'b0;
    endtask

    task automatic pulse_ba();
        #1 clk_ba = 1'b1; m_ba = bus_b;
        #1 clk_ba = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with both paths enabled and in stored mode
        cyc(); cyc();
        tag = "R1";
        check("reset b_out", b_out, 8'h00);
        check("reset a_out", a_out, 8'h00);
        check("reset b_oe", {7'd0, b_oe}, 8'h01);
        check("reset a_oe", {7'd0, a_oe}, 8'h01);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cyc();

        // R6: isolation, captures still work
        tag = "R6";
        setc(1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 8'h3C; ext_a_en = 1'b1; ext_b = 8'hA5; ext_b_en = 1'b1;
        cyc(); cyc();
        pulse_ab(); pulse_ba();
        check("isolated b_oe", {7'd0, b_oe}, 8'h00);
        check("isolated a_oe", {7'd0, a_oe}, 8'h00);
        cyc();

        // R5 and R2: playback of A word captured while isolated
        tag = "R5";
        ext_b_en = 1'b0;
        setc(1'b1, 1'b1, 1'b1, 1'b0);
        #1 check("stored A on B", b_out, 8'h3C);
        cyc(); cyc();

        // R3 and R4: B-to-A stored then live
        tag = "R4";
        ext_a_en = 1'b0;
        setc(1'b0, 1'b0, 1'b0, 1'b1);
        #1 check("stored B on A", a_out, 8'hA5);
        cyc();
        sel_ba = 1'b0;
        ext_b_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            ext_b = 8'h10 + 8'(i * 7);
            cyc();
        end
        cyc();
        #1 check("live B on A", a_out, bus_b);

        // R7: B driven live onto A, then captured into both registers
        tag = "R7";
        ext_b = 8'h5A;
        cyc(); cyc(); cyc();
        pulse_ba(); pulse_ab();
        ext_b_en = 1'b0;
        setc(1'b1, 1'b1, 1'b1, 1'b1);
        #1 check("B word via A register", b_out, 8'h5A);
        cyc();
        setc(1'b0, 1'b0, 1'b1, 1'b1);
        #1 check("B word in B register", a_out, 8'h5A);
        cyc();

        // R10: simultaneous stored playback both ways
        tag = "R10";
        setc(1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 8'h11; ext_a_en = 1'b1; ext_b = 8'hEE; ext_b_en = 1'b1;
        cyc(); cyc();
        pulse_ab(); pulse_ba();
        cyc();
        ext_a_en = 1'b0; ext_b_en = 1'b0;
        setc(1'b1, 1'b0, 1'b1, 1'b1);
        #1 check("stored A on B", b_out, 8'h11);
        check("stored B on A", a_out, 8'hEE);
        cyc(); cyc();
        check("bus B after swap", bus_b, 8'h11);
        check("bus A after swap", bus_a, 8'hEE);

        // R8: self-holding loop
        tag = "R8";
        setc(1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 8'h96; ext_a_en = 1'b1;
        cyc(); cyc();
        en_ab = 1'b1;
        cyc(); cyc();
        en_ba_n = 1'b0; ext_a_en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            cyc();
            check("held bus A", bus_a, 8'h96);
            check("held bus B", bus_b, 8'h96);
        end

        // R9: select switch between equal live and stored sources
        tag = "R9";
        setc(1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 8'hC3; ext_a_en = 1'b1;
        cyc(); cyc();
        pulse_ab();
        en_ab = 1'b1;
        cyc();
        b_changes = 0; mon_on = 1'b1;
        sel_ab = 1'b1; #1 sel_ab = 1'b0; #1 sel_ab = 1'b1;
        #1 mon_on = 1'b0;
        check("changes while switching", 8'(b_changes), 8'd0);
        check("value after switching", b_out, 8'hC3);
        cyc();
        ext_a_en = 1'b0;

        // R4 and R5: pseudo-random control and data patterns
        tag = "R5";
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            setc(lfsr[0], lfsr[1], lfsr[2], lfsr[3]);
            ext_a = lfsr[15:8]; ext_a_en = lfsr[4];
            ext_b = lfsr[7:0] ^ 8'h5F; ext_b_en = lfsr[5];
            if (lfsr[6]) pulse_ab();
            if (lfsr[7]) pulse_ba();
            cyc();
        end
        ext_a_en = 1'b0; ext_b_en = 1'b0;

        // R1: mid-run reset clears registers, keeps controls
        tag = "R1";
        setc(1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 8'h7E; ext_a_en = 1'b1; ext_b = 8'h81; ext_b_en = 1'b1;
        cyc(); cyc();
        pulse_ab(); pulse_ba();
        cyc();
        ext_a_en = 1'b0; ext_b_en = 1'b0;
        setc(1'b1, 1'b0, 1'b1, 1'b1);
        #1 check("pre-reset B", b_out, 8'h7E);
        rst_n = 1'b0; m_ab = '0; m_ba = '0;
        #1 check("reset b_out", b_out, 8'h00);
        check("reset a_out", a_out, 8'h00);
        check("reset keeps b_oe", {7'd0, b_oe}, 8'h01);
        check("reset keeps a_oe", {7'd0, a_oe}, 8'h01);
        cyc();
        rst_n = 1'b1;
        cyc(); cyc();

        cmp_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule